// File: doc/BRIEF.md
# Shadowed Nonvolatile SRAM Controller

This block is a synchronous model and controller for a byte-wide static memory in which every word has a nonvolatile shadow word. Ordinary reads and writes reach the static array through active-low chip, output and write strobes. A separate active-low nonvolatile strobe starts one of two whole-array transfers. A save copies every static word into the shadow array. A restore copies the shadow array back into the static array. A one-cycle power-restore pulse also starts a restore, so the static array is reloaded before any ordinary access is accepted.

Each transfer runs on its own once started. It moves one word per clock, from address 0 up to the top address, and holds a busy flag high for the whole walk. While busy is high the block ignores access strobes and further transfer strobes, and it leaves the data bus undriven. A saturating counter on a status port reports how many saves have completed. The bidirectional data bus is split into separate in, out and output-enable signals.

Top module: `nvsram_ctrl`

## Requirements
- R1: A write (ce_ni=0, we_ni=0, ne_ni=1, not busy) stores data_i at addr_i on the clock edge. A read (ce_ni=0, we_ni=1, ne_ni=1, not busy) captures the addressed word on the clock edge, and it shows on data_o after that edge.
- R2: data_oe_o is 1 exactly when ce_ni=0, oe_ni=0, we_ni=1, ne_ni=1 and busy_o=0. In every other case it is 0 and data_o is 0.
- R3: A falling edge of ne_ni (high at the previous edge, low now) with ce_ni=0 and we_ni=0 starts a save. The save copies every static word into the shadow array, and busy_o stays high for exactly 2**ADDR_W cycles.
- R4: A falling edge of ne_ni with ce_ni=0, we_ni=1 and oe_ni=0 starts a restore. The restore copies every shadow word into the static array, with the same busy length as a save.
- R5: A high pwr_restore_i while idle starts a restore on that edge, ahead of any strobe decoded on the same edge.
- R6: While busy_o is high, writes, reads and transfer strobes have no effect, and data_oe_o stays 0.
- R7: Reset (rst_ni low) clears every static word to 0, clears busy_o and the save count, and leaves the shadow array unchanged.
- R8: store_cnt_o rises by one at the end of each completed save and saturates at all ones. Restores leave it unchanged.
- R9: standby_o is 1 only when ce_ni=1 and no transfer is running. Taking ce_ni high during a transfer does not assert it.
- R10: Holding ne_ni low starts only one transfer. Another transfer needs ne_ni to return high first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_restore_i | input | 1 | Power-restore pulse; starts a restore |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| ne_ni | input | 1 | Nonvolatile transfer strobe, active low |
| addr_i | input | ADDR_W | Word address |
| data_i | input | DATA_W | Write data |
| data_o | output | DATA_W | Read data, 0 when not driven |
| data_oe_o | output | 1 | Data bus drive enable |
| busy_o | output | 1 | Transfer in progress |
| standby_o | output | 1 | Deselected and idle |
| store_cnt_o | output | CNT_W | Saturating count of completed saves |

## Verification
Read data is due one clock after the strobe edge. Each bench read holds its strobes for two falling edges, and the monitor compares the result on the second one, while the pins are still in the read state. busy_o rises one edge after a transfer strobe or power pulse and falls 2**ADDR_W edges later. The bench checks busy on the first falling edge after the strobe, and it counts busy falling edges to confirm the length. store_cnt_o, data_oe_o and standby_o are checked only after busy has dropped, or a short settling delay after the inputs change, since they are combinational or change on the closing edge.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    XF_NONE   = 2'd0,
    XF_STORE  = 2'd1,
    XF_RECALL = 2'd2
  } xfer_e;
endpackage

// File: rtl/nvs_decode.sv
module nvs_decode (
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic we_ni,
  input  logic ne_ni,
  input  logic ne_fall_i,
  input  logic busy_i,
  output logic rd_en_o,
  output logic wr_en_o,
  output logic store_req_o,
  output logic recall_req_o,
  output logic drive_o
);
  logic idle_sel;
  assign idle_sel     = ~ce_ni & ~busy_i;
  assign rd_en_o      = idle_sel & we_ni & ne_ni;
  assign wr_en_o      = idle_sel & ~we_ni & ne_ni;
  assign store_req_o  = idle_sel & ne_fall_i & ~we_ni;
  assign recall_req_o = idle_sel & ne_fall_i & we_ni & ~oe_ni;
  assign drive_o      = idle_sel & ~oe_ni & we_ni & ne_ni;
endmodule

// File: rtl/nvs_xfer_seq.sv
module nvs_xfer_seq
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_restore_i,
  input  logic              store_req_i,
  input  logic              recall_req_i,
  output logic              busy_o,
  output xfer_e             op_o,
  output logic [ADDR_W-1:0] idx_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] LastIdx = {ADDR_W{1'b1}};

  logic              busy_q;
  xfer_e             op_q;
  logic [ADDR_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= XF_NONE;
      idx_q  <= '0;
    end else if (!busy_q) begin
      idx_q <= '0;
      // power restore wins over any strobe on the same edge
      if (pwr_restore_i || recall_req_i) begin
        busy_q <= 1'b1;
        op_q   <= XF_RECALL;
      end else if (store_req_i) begin
        busy_q <= 1'b1;
        op_q   <= XF_STORE;
      end
    end else begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == LastIdx) begin
        busy_q <= 1'b0;
        op_q   <= XF_NONE;
      end
    end
  end

  assign busy_o = busy_q;
  assign op_o   = op_q;
  assign idx_o  = idx_q;
  assign done_o = busy_q && (idx_q == LastIdx);
endmodule

// File: rtl/nvs_sat_counter.sv
module nvs_sat_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (inc_i && cnt_q != CntMax) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_restore_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              ne_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              busy_o,
  output logic              standby_o,
  output logic [CNT_W-1:0]  store_cnt_o
);
  localparam int Depth = 1 << ADDR_W;

  logic [DATA_W-1:0] sram_q   [Depth];
  logic [DATA_W-1:0] shadow_q [Depth];
  logic [DATA_W-1:0] rd_q;
  logic              ne_q;
  logic              ne_fall;
  logic              rd_en, wr_en, store_req, recall_req, drive;
  logic              busy, done;
  xfer_e             op;
  logic [ADDR_W-1:0] idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ne_q <= 1'b1;
    else         ne_q <= ne_ni;
  end
  assign ne_fall = ne_q & ~ne_ni;

  nvs_decode u_dec (
    .ce_ni        (ce_ni),
    .oe_ni        (oe_ni),
    .we_ni        (we_ni),
    .ne_ni        (ne_ni),
    .ne_fall_i    (ne_fall),
    .busy_i       (busy),
    .rd_en_o      (rd_en),
    .wr_en_o      (wr_en),
    .store_req_o  (store_req),
    .recall_req_o (recall_req),
    .drive_o      (drive)
  );

  nvs_xfer_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pwr_restore_i (pwr_restore_i),
    .store_req_i   (store_req),
    .recall_req_i  (recall_req),
    .busy_o        (busy),
    .op_o          (op),
    .idx_o         (idx),
    .done_o        (done)
  );

  nvs_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (done && op == XF_STORE),
    .cnt_o  (store_cnt_o)
  );

  // static array: cleared by reset, loaded by restore, written by host
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < Depth; i++) sram_q[i] <= '0;
    end else if (busy && op == XF_RECALL) begin
      sram_q[idx] <= shadow_q[idx];
    end else if (wr_en) begin
      sram_q[addr_i] <= data_i;
    end
  end

  // shadow array: no reset, survives power loss
  always_ff @(posedge clk_i) begin
    if (busy && op == XF_STORE) shadow_q[idx] <= sram_q[idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rd_q <= '0;
    else if (rd_en) rd_q <= sram_q[addr_i];
  end

  assign data_o    = drive ? rd_q : '0;
  assign data_oe_o = drive;
  assign busy_o    = busy;
  assign standby_o = ce_ni & ~busy;
endmodule

// File: rtl/nvsram_ctrl_chk.sv
module nvsram_ctrl_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwr_restore_i,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic              we_ni,
  input logic              ne_ni,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic              busy_o,
  input logic              standby_o,
  input logic [CNT_W-1:0]  store_cnt_o
);
  localparam int Depth = 1 << ADDR_W;

  logic [ADDR_W:0] busy_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_len_q <= '0;
    else if (busy_o) busy_len_q <= busy_len_q + 1'b1;
    else             busy_len_q <= '0;
  end

  p_busy_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> busy_len_q == (ADDR_W+1)'(Depth));

  p_pwr_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_restore_i && !busy_o) |=> busy_o);

  p_hiz_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!data_oe_o && data_o == '0));

  p_oe_strobes_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!ce_ni && !oe_ni && we_ni && ne_ni));

  p_cnt_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(store_cnt_o) |-> (store_cnt_o == $past(store_cnt_o) + 1'b1));

  p_cnt_at_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(store_cnt_o) |-> $fell(busy_o));

  p_standby_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> (ce_ni && !busy_o));
endmodule

bind nvsram_ctrl nvsram_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pwr_restore_i (pwr_restore_i),
  .ce_ni         (ce_ni),
  .oe_ni         (oe_ni),
  .we_ni         (we_ni),
  .ne_ni         (ne_ni),
  .data_o        (data_o),
  .data_oe_o     (data_oe_o),
  .busy_o        (busy_o),
  .standby_o     (standby_o),
  .store_cnt_o   (store_cnt_o)
);

// File: tb/sim_nvsram_ctrl.sv
module sim_nvsram_ctrl;
  localparam int ClkPeriod = 10;
  localparam int ADDR_W    = 11;
  localparam int DATA_W    = 8;
  localparam int CNT_W     = 3;
  localparam int Depth     = 1 << ADDR_W;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] exp;
    string             req;
  } rd_item_t;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              pwr_restore_i = 1'b0;
  logic              ce_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1, ne_ni = 1'b1;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] data_i = '0;
  logic [DATA_W-1:0] data_o;
  logic              data_oe_o, busy_o, standby_o;
  logic [CNT_W-1:0]  store_cnt_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic rd_req = 1'b0;
  logic rd_flag = 1'b0;
  rd_item_t sb_q[$];

  always #(ClkPeriod/2) clk = ~clk;

  nvsram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_restore_i(pwr_restore_i),
    .ce_ni(ce_ni), .oe_ni(oe_ni), .we_ni(we_ni), .ne_ni(ne_ni),
    .addr_i(addr_i), .data_i(data_i), .data_o(data_o),
    .data_oe_o(data_oe_o), .busy_o(busy_o), .standby_o(standby_o),
    .store_cnt_o(store_cnt_o)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: read result due one edge after the strobe
  always @(posedge clk) rd_flag <= rd_req;
  always @(negedge clk) begin
    if (rd_flag) begin
      rd_item_t it;
      if (sb_q.size() == 0) begin
        check(1, 0, "R1 scoreboard empty");
      end else begin
        it = sb_q.pop_front();
        check({31'd0, data_oe_o}, 1, {it.req, " drive"});
        check({24'd0, data_o}, {24'd0, it.exp}, it.req);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected <200000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle();
    ce_ni = 1'b1; oe_ni = 1'b1; we_ni = 1'b1; ne_ni = 1'b1;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr_i = a[ADDR_W-1:0]; data_i = d[DATA_W-1:0];
    ce_ni = 1'b0; we_ni = 1'b0; oe_ni = 1'b1; ne_ni = 1'b1;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input int a, input int e, input string req);
    rd_item_t it;
    it.addr = a[ADDR_W-1:0]; it.exp = e[DATA_W-1:0]; it.req = req;
    sb_q.push_back(it);
    @(negedge clk);
    addr_i = a[ADDR_W-1:0];
    ce_ni = 1'b0; we_ni = 1'b1; oe_ni = 1'b0; ne_ni = 1'b1;
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
    idle();
  endtask

  task automatic strobe_store();
    @(negedge clk);
    ce_ni = 1'b0; we_ni = 1'b0; oe_ni = 1'b1; ne_ni = 1'b0;
  endtask

  task automatic strobe_recall();
    @(negedge clk);
    ce_ni = 1'b0; we_ni = 1'b1; oe_ni = 1'b0; ne_ni = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o === 1'b1 && n < Depth + 10) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; idle();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    int n;
    idle();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check({31'd0, busy_o}, 0, "R7 busy after reset");
    check({29'd0, store_cnt_o}, 0, "R7 count after reset");
    check({31'd0, standby_o}, 1, "R9 idle deselected");
    check({31'd0, data_oe_o}, 0, "R2 no drive when deselected");

    wr(0, 8'hA5); wr(1, 8'h3C); wr(Depth-1, 8'h81); wr(100, 8'h55);
    rd(0, 8'hA5, "R1 read a0");
    rd(1, 8'h3C, "R1 read a1");
    rd(Depth-1, 8'h81, "R1 read top");
    rd(100, 8'h55, "R1 read a100");
    rd(5, 8'h00, "R7 cleared word");

    // R2: write strobe and oe high both keep the bus undriven
    @(negedge clk);
    ce_ni = 1'b0; oe_ni = 1'b0; we_ni = 1'b0; addr_i = 200; data_i = 8'h99;
    #1 check({31'd0, data_oe_o}, 0, "R2 no drive while writing");
    @(negedge clk);
    ce_ni = 1'b0; oe_ni = 1'b1; we_ni = 1'b1;
    #1 check({31'd0, data_oe_o}, 0, "R2 no drive with oe high");
    @(negedge clk);
    ce_ni = 1'b0; oe_ni = 1'b0; we_ni = 1'b1; ne_ni = 1'b1;
    #1 check({31'd0, data_oe_o}, 1, "R2 drive on read strobes");
    idle();

    // save with interference during busy
    strobe_store();
    @(negedge clk);
    check({31'd0, busy_o}, 1, "R3 busy after save strobe");
    ce_ni = 1'b0; we_ni = 1'b0; ne_ni = 1'b1; addr_i = 0; data_i = 8'hFF;
    @(negedge clk);
    ce_ni = 1'b0; we_ni = 1'b1; oe_ni = 1'b0; ne_ni = 1'b1;
    #1 check({31'd0, data_oe_o}, 0, "R6 no drive while busy");
    @(negedge clk);
    idle();
    #1 check({31'd0, standby_o}, 0, "R9 no standby while busy");
    wait_idle(n);
    check(n + 2, Depth, "R3 save length");
    check({29'd0, store_cnt_o}, 1, "R8 count after first save");
    check({31'd0, standby_o}, 1, "R9 standby after transfer");
    rd(0, 8'hA5, "R6 write during busy ignored");

    // overwrite, then restore
    wr(0, 8'h11); wr(1, 8'h22);
    rd(0, 8'h11, "R1 overwrite");
    strobe_recall();
    @(negedge clk);
    idle();
    check({31'd0, busy_o}, 1, "R4 busy after restore strobe");
    wait_idle(n);
    check(n, Depth, "R4 restore length");
    check({29'd0, store_cnt_o}, 1, "R8 restore leaves count");
    rd(0, 8'hA5, "R4 restored a0");
    rd(1, 8'h3C, "R4 restored a1");
    rd(Depth-1, 8'h81, "R4 restored top");

    // R10: ne held low across and after the transfer
    strobe_store();
    @(negedge clk);
    wait_idle(n);
    check(n, Depth, "R3 save length uninterrupted");
    repeat (3) @(negedge clk);
    check({31'd0, busy_o}, 0, "R10 held strobe no retrigger");
    check({29'd0, store_cnt_o}, 2, "R10 single save counted");
    idle();

    // R7/R5: reset clears static array, shadow kept, power restore reloads
    wr(0, 8'h77);
    do_reset();
    #1 check({29'd0, store_cnt_o}, 0, "R7 count cleared");
    rd(0, 8'h00, "R7 static cleared");
    rd(Depth-1, 8'h00, "R7 static top cleared");
    @(negedge clk);
    pwr_restore_i = 1'b1;
    ce_ni = 1'b0; we_ni = 1'b0; ne_ni = 1'b0; // save strobe loses to power restore
    @(negedge clk);
    pwr_restore_i = 1'b0; idle();
    check({31'd0, busy_o}, 1, "R5 busy after power pulse");
    wait_idle(n);
    check(n, Depth, "R5 restore length");
    check({29'd0, store_cnt_o}, 0, "R5 restore won over save");
    rd(0, 8'hA5, "R5 shadow a0 retained");
    rd(Depth-1, 8'h81, "R5 shadow top retained");

    // R8: saturation at all ones
    for (int k = 1; k <= (1 << CNT_W); k++) begin
      strobe_store();
      @(negedge clk);
      idle();
      wait_idle(n);
      check({29'd0, store_cnt_o}, (k < (1 << CNT_W)) ? k : (1 << CNT_W) - 1, "R8 count step");
    end

    repeat (3) @(negedge clk);
    check(sb_q.size(), 0, "R1 scoreboard drained");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule